// File: doc/BRIEF.md
# I2C Script Sequencer

This block runs short, pre-stored I2C command scripts on behalf of software. The scripts are byte opcodes held in an internal script memory. Each opcode names a transaction type and is followed by its operand bytes. Software writes a trigger word to start script P. Later it polls a status word, then reads an error count and the collected read bytes from fixed control-port locations. A second port gives software byte-wide read and write access to the script memory. After reset that memory holds a default image.

The sequencer fetches one script byte per cycle from a start offset held in a per-script offset table. It assembles one transaction and hands it to an attached transaction master, which owns all bus-level timing and clock stretching. It then waits for that transaction to complete. It captures each successfully read byte as a result and counts each NACKed transaction, then moves on to the next opcode. The script ends when the sequencer meets the end code or any unrecognised opcode.

The sequencer state machine has these states:

| State | Role |
|---|---|
| ST_IDLE | Waits for a trigger. |
| ST_OPC | Fetches the opcode. |
| ST_ADDR | Fetches the slave address. |
| ST_REG | Fetches the register byte. |
| ST_DATA | Fetches the data byte, for write types only. |
| ST_ISSUE | Raises the request once the master is not busy. |
| ST_WAIT | Waits for the master's done pulse. |
| ST_DONE | Holds the done status. |

The transitions are:

- ST_IDLE goes to ST_OPC on an accepted trigger.
- ST_OPC goes to ST_ADDR on a known opcode, or to ST_DONE otherwise.
- ST_ADDR goes to ST_REG.
- ST_REG goes to ST_ISSUE for a read, or to ST_DATA for the two write types.
- ST_DATA goes to ST_ISSUE.
- ST_ISSUE goes to ST_WAIT when the master is not busy.
- ST_WAIT goes to ST_OPC on done.
- ST_DONE goes to ST_IDLE on a status read that returns done.

Top module: `i2c_script_sequencer`

## Requirements
- R1: With N scripts, writing the value 1 to control word P (0 ≤ P < N) while the status is idle starts script P at the offset held in control word N+P. After reset, that offset is P×(DEPTH/N), and software can read it back or rewrite it.
- R2: A trigger is ignored when the status is not idle at that clock edge, and also when the written value is not 1. An ignored trigger issues no transaction and leaves the status and results unchanged.
- R3: The status word at index 3N reads 0 when idle, 1 when running and 2 when done. The done state holds until a status read returns 2. After that read the status is idle again.
- R4: There are three opcodes:
  - 0x01 is a write, with operands address, register and data. It issues transaction type 0.
  - 0x02 is a read, with operands address and register. It issues type 1 with data 0.
  - 0x03 is a write-then-read, with operands address, register and data. It issues type 2.
  
  Any other byte, including the end code 0x00, ends the script.
- R5: Each read or write-then-read that is not NACKed stores its returned byte as the next result, at word 3N+2+k. At most MAX_RESULTS results are kept, and later ones are dropped.
- R6: Each NACKed transaction increments the error count at word 3N+1. A NACKed read stores no result, and the sequencer continues with the next opcode.
- R7: An accepted trigger clears the error count and every result word to 0.
- R8: The script memory port reads and writes bytes, and a read returns its data one cycle after the request. After reset the memory holds the following image:
  - 02 4C 00 00 from byte 0.
  - 01 20 06 5A 03 20 02 33 00 from byte DEPTH/N.
  - 0x00 everywhere else.
- R9: Control-port reads return data one cycle after the request. Trigger words and unmapped words read 0.
- R10: At most one transaction is outstanding. A request is raised only while the master is not busy, and only after the previous transaction's done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control-port write strobe |
| ctl_rd | input | 1 | Control-port read strobe |
| ctl_addr | input | CTL_AW | Control-port word index |
| ctl_wdata | input | 32 | Control-port write data |
| ctl_rdata | output | 32 | Control-port read data, one cycle after ctl_rd |
| pram_wr | input | 1 | Script-memory write strobe |
| pram_rd | input | 1 | Script-memory read strobe |
| pram_addr | input | PW | Script-memory byte address |
| pram_wdata | input | 8 | Script-memory write byte |
| pram_rdata | output | 8 | Script-memory read byte, one cycle after pram_rd |
| xfer_req | output | 1 | One-cycle transaction request |
| xfer_op | output | 2 | Transaction type: 0 write, 1 read, 2 write-then-read |
| xfer_addr | output | 7 | Slave address |
| xfer_reg | output | 8 | Register byte |
| xfer_wdata | output | 8 | Data byte |
| xfer_busy | input | 1 | Master busy |
| xfer_done | input | 1 | One-cycle completion pulse |
| xfer_nack | input | 1 | Completion carried a NACK, valid with xfer_done |
| xfer_rdata | input | 8 | Returned byte, valid with xfer_done |

## Verification
A software write into the script memory can land in the same cycle as the sequencer's fetch of that byte. The bench provokes this by triggering script 0. It then writes the unknown code 0x07 to byte 0 so that the write lands on exactly the edge where the sequencer latches the opcode. The bench expects the old opcode to be used, so a read transaction to 0x4C still appears. A read-back of byte 0 afterwards must return 0x07. A second collision, a trigger arriving while the sequencer is running, is judged by the transaction scoreboard and by the results staying intact.

// File: rtl/isr_pkg.sv
package isr_pkg;

    localparam logic [7:0] OPC_END  = 8'h00;
    localparam logic [7:0] OPC_WR   = 8'h01;
    localparam logic [7:0] OPC_RD   = 8'h02;
    localparam logic [7:0] OPC_WRRD = 8'h03;

    localparam logic [1:0] XF_WR   = 2'd0;
    localparam logic [1:0] XF_RD   = 2'd1;
    localparam logic [1:0] XF_WRRD = 2'd2;

    localparam logic [1:0] STAT_IDLE = 2'd0;
    localparam logic [1:0] STAT_RUN  = 2'd1;
    localparam logic [1:0] STAT_DONE = 2'd2;

    // Power-up script image: script 0 at byte 0, script 1 at byte 'stride'.
    function automatic logic [7:0] boot_byte(input int idx, input int stride);
        logic [7:0] b;
        b = OPC_END;
        case (idx)
            0: b = OPC_RD;
            1: b = 8'h4C;
            default: ;
        endcase
        if (idx >= stride) begin
            case (idx - stride)
                0: b = OPC_WR;
                1: b = 8'h20;
                2: b = 8'h06;
                3: b = 8'h5A;
                4: b = OPC_WRRD;
                5: b = 8'h20;
                6: b = 8'h02;
                7: b = 8'h33;
                default: ;
            endcase
        end
        return b;
    endfunction

endpackage

// File: rtl/isr_pram.sv
module isr_pram
    import isr_pkg::*;
#(
    parameter int PW     = 6,
    parameter int STRIDE = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sw_wr,
    input  logic          sw_rd,
    input  logic [PW-1:0] sw_addr,
    input  logic [7:0]    sw_wdata,
    output logic [7:0]    sw_rdata,
    input  logic [PW-1:0] fetch_pc,
    output logic [7:0]    fetch_byte
);
    localparam int DEPTH = 1 << PW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= boot_byte(i, STRIDE);
            end
            sw_rdata <= '0;
        end else begin
            if (sw_wr) begin
                mem[sw_addr] <= sw_wdata;
            end
            if (sw_rd) begin
                sw_rdata <= mem[sw_addr];
            end
        end
    end

    // Fetch sees the contents as they stand before the current edge.
    assign fetch_byte = mem[fetch_pc];

    // R8
    pram_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_rd |=> $stable(sw_rdata));

endmodule

// File: rtl/isr_engine.sv
module isr_engine
    import isr_pkg::*;
#(
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_go,
    input  logic [PW-1:0] start_pc,
    output logic [PW-1:0] fetch_pc,
    input  logic [7:0]    fetch_byte,
    output logic [1:0]    status,
    input  logic          done_ack,
    output logic          m_req,
    output logic [1:0]    m_op,
    output logic [6:0]    m_addr,
    output logic [7:0]    m_reg,
    output logic [7:0]    m_wdata,
    input  logic          m_busy,
    input  logic          m_done,
    input  logic          m_nack,
    input  logic [7:0]    m_rdata,
    output logic          res_push,
    output logic [7:0]    res_byte,
    output logic          err_inc
);
    typedef enum logic [2:0] {
        ST_IDLE, ST_OPC, ST_ADDR, ST_REG, ST_DATA, ST_ISSUE, ST_WAIT, ST_DONE
    } st_e;

    localparam logic [PW-1:0] PC_ONE = {{(PW-1){1'b0}}, 1'b1};

    st_e           state, nxt;
    logic [PW-1:0] pc;
    logic [7:0]    opc, reg_b, dat_b;
    logic [6:0]    adr_b;
    logic          opc_ok;

    assign opc_ok = (fetch_byte == OPC_WR) || (fetch_byte == OPC_RD) || (fetch_byte == OPC_WRRD);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start_go) nxt = ST_OPC;
            ST_OPC:   nxt = opc_ok ? ST_ADDR : ST_DONE;
            ST_ADDR:  nxt = ST_REG;
            ST_REG:   nxt = (opc == OPC_RD) ? ST_ISSUE : ST_DATA;
            ST_DATA:  nxt = ST_ISSUE;
            ST_ISSUE: if (!m_busy) nxt = ST_WAIT;
            ST_WAIT:  if (m_done) nxt = ST_OPC;
            ST_DONE:  if (done_ack) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc    <= '0;
            opc   <= OPC_END;
            adr_b <= '0;
            reg_b <= '0;
            dat_b <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start_go) pc <= start_pc;
                ST_OPC: if (opc_ok) begin
                    opc <= fetch_byte;
                    pc  <= pc + PC_ONE;
                end
                ST_ADDR: begin
                    adr_b <= fetch_byte[6:0];
                    pc    <= pc + PC_ONE;
                end
                ST_REG: begin
                    reg_b <= fetch_byte;
                    pc    <= pc + PC_ONE;
                    if (opc == OPC_RD) dat_b <= '0;
                end
                ST_DATA: begin
                    dat_b <= fetch_byte;
                    pc    <= pc + PC_ONE;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        fetch_pc = pc;
        m_addr   = adr_b;
        m_reg    = reg_b;
        m_wdata  = dat_b;
        res_byte = m_rdata;
        m_req    = (state == ST_ISSUE) && !m_busy;
        res_push = (state == ST_WAIT) && m_done && !m_nack && (opc != OPC_WR);
        err_inc  = (state == ST_WAIT) && m_done && m_nack;
        if (opc == OPC_WR)      m_op = XF_WR;
        else if (opc == OPC_RD) m_op = XF_RD;
        else                    m_op = XF_WRRD;
        if (state == ST_IDLE)      status = STAT_IDLE;
        else if (state == ST_DONE) status = STAT_DONE;
        else                       status = STAT_RUN;
    end

    // R1
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start_go) |=> (state == ST_OPC && fetch_pc == $past(start_pc)));

    // R3
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !done_ack) |=> (status == STAT_DONE));

    // R10
    one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |=> !m_req);

endmodule

// File: rtl/isr_ctl_regs.sv
module isr_ctl_regs
    import isr_pkg::*;
#(
    parameter int NL = 4,
    parameter int NR = 8,
    parameter int PW = 6,
    parameter int AW = 5,
    parameter int DW = 32,
    parameter int EW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic          ctl_rd,
    input  logic [AW-1:0] ctl_addr,
    input  logic [DW-1:0] ctl_wdata,
    output logic [DW-1:0] ctl_rdata,
    input  logic [1:0]    status,
    input  logic          res_push,
    input  logic [7:0]    res_byte,
    input  logic          err_inc,
    output logic          start_go,
    output logic [PW-1:0] start_pc,
    output logic          done_ack
);
    localparam int STRIDE   = (1 << PW) / NL;
    localparam int STAT_IDX = 3 * NL;
    localparam int ERR_IDX  = STAT_IDX + 1;
    localparam int RES_IDX  = STAT_IDX + 2;
    localparam int CW       = $clog2(NR + 1);

    logic [PW-1:0] offs [NL];
    logic [7:0]    res  [NR];
    logic [CW-1:0] res_cnt;
    logic [EW-1:0] err_cnt;
    logic [DW-1:0] rd_val;
    int            ai;

    assign ai       = int'(ctl_addr);
    assign start_go = ctl_wr && (ai < NL) && (ctl_wdata == {{(DW-1){1'b0}}, 1'b1})
                      && (status == STAT_IDLE);
    assign done_ack = ctl_rd && (ai == STAT_IDX) && (status == STAT_DONE);

    always_comb begin
        start_pc = offs[0];
        for (int p = 0; p < NL; p++) begin
            if (ai == p) start_pc = offs[p];
        end
    end

    always_comb begin
        rd_val = '0;
        for (int p = 0; p < NL; p++) begin
            if (ai == NL + p) rd_val = {{(DW-PW){1'b0}}, offs[p]};
        end
        for (int k = 0; k < NR; k++) begin
            if (ai == RES_IDX + k) rd_val = {{(DW-8){1'b0}}, res[k]};
        end
        if (ai == STAT_IDX) rd_val = {{(DW-2){1'b0}}, status};
        if (ai == ERR_IDX)  rd_val = {{(DW-EW){1'b0}}, err_cnt};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NL; p++) offs[p] <= PW'(p * STRIDE);
            for (int k = 0; k < NR; k++) res[k] <= '0;
            res_cnt   <= '0;
            err_cnt   <= '0;
            ctl_rdata <= '0;
        end else begin
            if (ctl_rd) ctl_rdata <= rd_val;
            for (int p = 0; p < NL; p++) begin
                if (ctl_wr && ai == NL + p) offs[p] <= ctl_wdata[PW-1:0];
            end
            if (start_go) begin
                for (int k = 0; k < NR; k++) res[k] <= '0;
                res_cnt <= '0;
                err_cnt <= '0;
            end else begin
                if (res_push && res_cnt < CW'(NR)) begin
                    for (int k = 0; k < NR; k++) begin
                        if (res_cnt == CW'(k)) res[k] <= res_byte;
                    end
                    res_cnt <= res_cnt + 1'b1;
                end
                if (err_inc) err_cnt <= err_cnt + 1'b1;
            end
        end
    end

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_go |=> (err_cnt == '0 && res_cnt == '0));

    // R5
    res_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_cnt <= CW'(NR));

    // R6
    err_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_inc && !start_go) |=> (err_cnt == $past(err_cnt) + 1'b1));

    // R9
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rd |=> $stable(ctl_rdata));

endmodule

// File: rtl/i2c_script_sequencer.sv
module i2c_script_sequencer
    import isr_pkg::*;
#(
    parameter int NUM_LISTS   = 4,
    parameter int MAX_RESULTS = 8,
    parameter int PRAM_DEPTH  = 64,
    parameter int PW          = $clog2(PRAM_DEPTH),
    parameter int CTL_AW      = $clog2(3 * NUM_LISTS + 2 + MAX_RESULTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_rd,
    input  logic [CTL_AW-1:0] ctl_addr,
    input  logic [31:0]       ctl_wdata,
    output logic [31:0]       ctl_rdata,
    input  logic              pram_wr,
    input  logic              pram_rd,
    input  logic [PW-1:0]     pram_addr,
    input  logic [7:0]        pram_wdata,
    output logic [7:0]        pram_rdata,
    output logic              xfer_req,
    output logic [1:0]        xfer_op,
    output logic [6:0]        xfer_addr,
    output logic [7:0]        xfer_reg,
    output logic [7:0]        xfer_wdata,
    input  logic              xfer_busy,
    input  logic              xfer_done,
    input  logic              xfer_nack,
    input  logic [7:0]        xfer_rdata
);
    localparam int STRIDE = PRAM_DEPTH / NUM_LISTS;

    logic [PW-1:0] fetch_pc, start_pc;
    logic [7:0]    fetch_byte, res_byte;
    logic [1:0]    status;
    logic          start_go, done_ack, res_push, err_inc;

    isr_pram #(.PW(PW), .STRIDE(STRIDE)) u_pram (
        .clk(clk), .rst_n(rst_n),
        .sw_wr(pram_wr), .sw_rd(pram_rd), .sw_addr(pram_addr),
        .sw_wdata(pram_wdata), .sw_rdata(pram_rdata),
        .fetch_pc(fetch_pc), .fetch_byte(fetch_byte)
    );

    isr_engine #(.PW(PW)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .start_go(start_go), .start_pc(start_pc),
        .fetch_pc(fetch_pc), .fetch_byte(fetch_byte),
        .status(status), .done_ack(done_ack),
        .m_req(xfer_req), .m_op(xfer_op), .m_addr(xfer_addr),
        .m_reg(xfer_reg), .m_wdata(xfer_wdata),
        .m_busy(xfer_busy), .m_done(xfer_done), .m_nack(xfer_nack),
        .m_rdata(xfer_rdata),
        .res_push(res_push), .res_byte(res_byte), .err_inc(err_inc)
    );

    isr_ctl_regs #(.NL(NUM_LISTS), .NR(MAX_RESULTS), .PW(PW), .AW(CTL_AW), .DW(32)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .ctl_addr(ctl_addr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .status(status), .res_push(res_push), .res_byte(res_byte),
        .err_inc(err_inc),
        .start_go(start_go), .start_pc(start_pc), .done_ack(done_ack)
    );

endmodule

// File: tb/i2c_script_sequencer_tb_top.sv
module i2c_script_sequencer_tb_top;
    localparam int NL = 4;
    localparam int NR = 8;
    localparam int DEPTH = 64;
    localparam int PW = 6;
    localparam int AW = 5;
    localparam int STATW = 3 * NL;
    localparam int ERRW = STATW + 1;
    localparam int RESW = STATW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 0, ctl_rd = 0;
    logic [AW-1:0] ctl_addr = '0;
    logic [31:0] ctl_wdata = '0, ctl_rdata;
    logic pram_wr = 0, pram_rd = 0;
    logic [PW-1:0] pram_addr = '0;
    logic [7:0] pram_wdata = '0, pram_rdata;
    logic xfer_req;
    logic [1:0] xfer_op;
    logic [6:0] xfer_addr;
    logic [7:0] xfer_reg, xfer_wdata;
    logic m_busy, m_done, m_nack, ext_busy = 1'b0;
    logic [7:0] m_rdata;
    logic [2:0] m_cnt;
    logic [6:0] la;
    logic [7:0] lr, ld;

    int n_chk = 0, n_err = 0;
    bit finished = 0;

    typedef struct packed { logic [1:0] op; logic [6:0] a; logic [7:0] r; logic [7:0] d; } xf_t;
    xf_t expq[$];

    always #2 clk = ~clk;

    i2c_script_sequencer dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .ctl_addr(ctl_addr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .pram_wr(pram_wr), .pram_rd(pram_rd), .pram_addr(pram_addr),
        .pram_wdata(pram_wdata), .pram_rdata(pram_rdata),
        .xfer_req(xfer_req), .xfer_op(xfer_op), .xfer_addr(xfer_addr),
        .xfer_reg(xfer_reg), .xfer_wdata(xfer_wdata),
        .xfer_busy(m_busy | ext_busy), .xfer_done(m_done), .xfer_nack(m_nack),
        .xfer_rdata(m_rdata)
    );

    function automatic logic [7:0] dev_val(logic [6:0] a, logic [7:0] r, logic [7:0] d);
        return r ^ {1'b0, a} ^ {d[6:0], 1'b0} ^ 8'h3C;
    endfunction

    // Transaction master model: address 0x7F never acknowledges.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; m_nack <= 0; m_rdata <= '0; m_cnt <= '0;
            la <= '0; lr <= '0; ld <= '0;
        end else begin
            m_done <= 0;
            if (!m_busy && !ext_busy && xfer_req) begin
                m_busy <= 1; m_cnt <= 3'd3;
                la <= xfer_addr; lr <= xfer_reg; ld <= xfer_wdata;
            end else if (m_busy) begin
                if (m_cnt == 3'd1) begin
                    m_busy <= 0; m_done <= 1;
                    m_nack <= (la == 7'h7F);
                    m_rdata <= dev_val(la, lr, ld);
                end
                m_cnt <= m_cnt - 3'd1;
            end
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Scoreboard monitor: every request is popped and compared (R4, R10).
    always @(negedge clk) begin
        if (rst_n && xfer_req) begin
            chk("R10", {31'b0, ext_busy | m_busy}, 32'd0);
            if (expq.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL R2: actual unexpected transaction %0h/%0h expected none", xfer_addr, xfer_reg);
            end else begin
                xf_t e;
                e = expq.pop_front();
                chk("R4", {xfer_op, xfer_addr, xfer_reg, xfer_wdata}, {7'b0, e});
            end
        end
    end

    task automatic push_x(logic [1:0] op, logic [6:0] a, logic [7:0] r, logic [7:0] d);
        xf_t e;
        e.op = op; e.a = a; e.r = r; e.d = d;
        expq.push_back(e);
    endtask

    // All bus tasks are entered just after a falling edge.
    task automatic ctl_write(int a, logic [31:0] d);
        ctl_wr = 1; ctl_addr = AW'(a); ctl_wdata = d;
        @(negedge clk);
        ctl_wr = 0;
    endtask

    task automatic ctl_read(int a, output logic [31:0] d);
        ctl_rd = 1; ctl_addr = AW'(a);
        @(negedge clk);
        ctl_rd = 0;
        d = ctl_rdata;
    endtask

    task automatic pram_write(int a, logic [7:0] d);
        pram_wr = 1; pram_addr = PW'(a); pram_wdata = d;
        @(negedge clk);
        pram_wr = 0;
    endtask

    task automatic pram_read(int a, output logic [7:0] d);
        pram_rd = 1; pram_addr = PW'(a);
        @(negedge clk);
        pram_rd = 0;
        d = pram_rdata;
    endtask

    task automatic wait_done();
        logic [31:0] v;
        v = 0;
        for (int i = 0; i < 300; i++) begin
            ctl_read(STATW, v);
            if (v == 32'd2) break;
        end
        chk("R3 done", v, 32'd2);
        ctl_read(STATW, v);
        chk("R3 idle after read", v, 32'd0);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        end
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [7:0] b;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // Reset state (R3, R1, R9, R8)
        ctl_read(STATW, v);  chk("R3 reset status", v, 0);
        ctl_read(ERRW, v);   chk("R6 reset errors", v, 0);
        ctl_read(RESW, v);   chk("R5 reset result", v, 0);
        ctl_read(NL + 2, v); chk("R1 default offset", v, 32);
        ctl_read(1, v);      chk("R9 trigger word reads 0", v, 0);
        pram_read(0, b);     chk("R8 image byte 0", {24'b0, b}, 32'h02);
        pram_read(20, b);    chk("R8 image byte 20", {24'b0, b}, 32'h03);
        pram_read(63, b);    chk("R8 image tail", {24'b0, b}, 32'h00);

        // Script 0: one read (R1, R4, R5)
        push_x(2'd1, 7'h4C, 8'h00, 8'h00);
        ctl_write(0, 1);
        wait_done();
        ctl_read(RESW, v);   chk("R5 script0 result", v, {24'b0, dev_val(7'h4C, 8'h00, 8'h00)});
        ctl_read(ERRW, v);   chk("R6 script0 errors", v, 0);

        // Script 1 with master held busy, trigger while running ignored (R10, R2)
        push_x(2'd0, 7'h20, 8'h06, 8'h5A);
        push_x(2'd2, 7'h20, 8'h02, 8'h33);
        ext_busy = 1'b1;
        ctl_write(1, 1);
        repeat (30) @(negedge clk);
        chk("R10 held while busy", expq.size(), 2);
        ctl_read(STATW, v);  chk("R3 running", v, 1);
        ctl_write(0, 1);
        ext_busy = 1'b0;
        wait_done();
        chk("R2 queue drained", expq.size(), 0);
        ctl_read(RESW, v);   chk("R5 script1 result", v, {24'b0, dev_val(7'h20, 8'h02, 8'h33)});
        ctl_read(RESW + 1, v); chk("R5 write makes no result", v, 0);

        // Trigger with value 2 ignored (R2)
        ctl_write(0, 2);
        repeat (10) @(negedge clk);
        ctl_read(STATW, v);  chk("R2 value 2 ignored", v, 0);
        ctl_read(RESW, v);   chk("R2 results kept", v, {24'b0, dev_val(7'h20, 8'h02, 8'h33)});

        // NACK script at 32 (R6, R4, R8 write)
        pram_write(32, 8'h02); pram_write(33, 8'h7F); pram_write(34, 8'h01);
        pram_write(35, 8'h01); pram_write(36, 8'h7F); pram_write(37, 8'h09); pram_write(38, 8'h44);
        pram_write(39, 8'h02); pram_write(40, 8'h11); pram_write(41, 8'h05);
        pram_write(42, 8'h03); pram_write(43, 8'h22); pram_write(44, 8'h06); pram_write(45, 8'h10);
        pram_write(46, 8'h00);
        pram_read(36, b);    chk("R8 write readback", {24'b0, b}, 32'h7F);
        push_x(2'd1, 7'h7F, 8'h01, 8'h00);
        push_x(2'd0, 7'h7F, 8'h09, 8'h44);
        push_x(2'd1, 7'h11, 8'h05, 8'h00);
        push_x(2'd2, 7'h22, 8'h06, 8'h10);
        ctl_write(2, 1);
        wait_done();
        ctl_read(ERRW, v);   chk("R6 two nacks", v, 2);
        ctl_read(RESW, v);   chk("R6 nacked read skipped", v, {24'b0, dev_val(7'h11, 8'h05, 8'h00)});
        ctl_read(RESW + 1, v); chk("R5 second result", v, {24'b0, dev_val(7'h22, 8'h06, 8'h10)});
        ctl_read(RESW + 2, v); chk("R5 unused result", v, 0);

        // New start clears counts (R7)
        push_x(2'd1, 7'h4C, 8'h00, 8'h00);
        ctl_write(0, 1);
        wait_done();
        ctl_read(ERRW, v);   chk("R7 errors cleared", v, 0);
        ctl_read(RESW + 1, v); chk("R7 results cleared", v, 0);

        // Unknown opcode ends script (R4)
        pram_write(48, 8'h07);
        ctl_write(3, 1);
        wait_done();
        chk("R4 unknown opcode no transaction", expq.size(), 0);

        // Offset rewrite (R1)
        ctl_write(NL + 3, 32);
        ctl_read(NL + 3, v); chk("R1 offset readback", v, 32);
        push_x(2'd1, 7'h7F, 8'h01, 8'h00);
        push_x(2'd0, 7'h7F, 8'h09, 8'h44);
        push_x(2'd1, 7'h11, 8'h05, 8'h00);
        push_x(2'd2, 7'h22, 8'h06, 8'h10);
        ctl_write(3, 1);
        wait_done();
        ctl_read(ERRW, v);   chk("R1 relocated script errors", v, 2);

        // Script write colliding with opcode fetch (R8, R4)
        push_x(2'd1, 7'h4C, 8'h00, 8'h00);
        ctl_write(0, 1);
        pram_write(0, 8'h07);
        wait_done();
        chk("R4 old opcode used", expq.size(), 0);
        pram_read(0, b);     chk("R8 colliding write stored", {24'b0, b}, 32'h07);
        pram_write(0, 8'h02);

        // Result overflow: nine reads, eight kept (R5)
        for (int k = 0; k < 9; k++) begin
            pram_write(32 + 3 * k, 8'h02);
            pram_write(33 + 3 * k, 8'h11);
            pram_write(34 + 3 * k, 8'(8'h40 + k));
            push_x(2'd1, 7'h11, 8'(8'h40 + k), 8'h00);
        end
        pram_write(59, 8'h00);
        ctl_write(2, 1);
        wait_done();
        chk("R5 overflow all issued", expq.size(), 0);
        ctl_read(RESW + 7, v); chk("R5 eighth result", v, {24'b0, dev_val(7'h11, 8'h47, 8'h00)});
        ctl_read(RESW, v);   chk("R5 first result kept", v, {24'b0, dev_val(7'h11, 8'h40, 8'h00)});
        ctl_read(RESW + NR, v); chk("R9 unmapped word", v, 0);

        repeat (5) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        end
        $finish;
    end

endmodule